// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Sequencer

This block is the operand front end of an 8-bit processor core. When the decoder has recognised an instruction, it pulses `start_i` with a 4-bit addressing-mode code, the two index register values and the address of the first byte after the opcode. The sequencer then reads any operand bytes that follow in the instruction stream. It resolves the effective address, including zero-page pointers, index additions and page-crossing corrections, and finally reads the operand itself. It uses a single-byte memory read port with at most one access per clock. It asks for one program-counter increment for each instruction byte it consumes.

At completion it pulses `done_o` for one cycle and presents the operand byte and the 16-bit effective address. Both stay on their outputs until the next completion, so a store or read-modify-write stage can reuse the address. Memory reads are combinational: `mem_data_i` must reflect `mem_addr_o` within the same cycle that `mem_rd_o` is high.

Top module: `opfetch_seq`

## Requirements
- R1: A start is accepted only while `busy_o` is low. A `start_i` seen while busy has no effect on the running operation, its result or its latency, and it produces no extra completion.
- R2: Mode 0 (immediate) returns the byte at `pc_i` as the operand, with `pc_i` as the effective address. `done_o` rises 1 edge after the accepting edge.
- R3: Mode 1 (zero page) uses address {0x00, b}, where b is the first instruction byte, and completes after 2 edges. Modes 2 and 3 (zero page indexed by X, respectively Y) use {0x00, (b + index) mod 256} and complete after 3 edges. The sum never leaves page zero.
- R4: Mode 4 (absolute) reads the address low byte at `pc_i`, then the high byte at `pc_i`+1. It uses {high, low} and completes after 3 edges.
- R5: Modes 5 and 6 (absolute indexed by X, respectively Y) add the index to the low byte. Without a carry out of bit 7 they complete after 3 edges. With a carry, the high byte is incremented modulo 256 and they complete after 4 edges.
- R6: Mode 7 (indexed indirect, X) forms pointer p = (b + X) mod 256. It reads the address low byte at {0x00, p} and the high byte at {0x00, (p+1) mod 256}, then completes after 5 edges.
- R7: Mode 8 (indirect indexed, Y) reads a base low byte at {0x00, b} and a base high byte at {0x00, (b+1) mod 256}, then adds Y to the base. It completes after 4 edges without a low-byte carry and after 5 edges with one, the high byte then being incremented.
- R8: Mode 9 (implied) pulses `done_o` right after the accepting edge. It makes no memory read and no increment request, and it leaves `ea_o` and `operand_o` unchanged.
- R9: Mode codes 10 to 15 pulse `reject_o` right after the accepting edge. They cause no `done_o`, no memory read and no state change.
- R10: `done_o` is a one-cycle pulse that occurs only while idle. `ea_o` and `operand_o` hold their values while the block stays idle.
- R11: `pc_inc_o` pulses once per instruction byte consumed: once for modes 0 to 3, 7 and 8, and twice for modes 4 to 6. The number of memory reads per operation is 1 for immediate, 2 for zero page and zero page indexed, 3 for the absolute modes and 4 for both indirect modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operand fetch (honoured only when idle) |
| mode_i | input | 4 | Addressing-mode code |
| idx_x_i | input | 8 | X index value, sampled at start |
| idx_y_i | input | 8 | Y index value, sampled at start |
| pc_i | input | 16 | Address of first byte after the opcode, sampled at start |
| mem_addr_o | output | 16 | Memory read address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_data_i | input | 8 | Read data for `mem_addr_o`, same cycle |
| pc_inc_o | output | 1 | Request to advance the program counter by one |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| reject_o | output | 1 | One-cycle pulse for an unsupported mode code |
| operand_o | output | 8 | Fetched operand, held after completion |
| ea_o | output | 16 | Effective address, held after completion |

## Verification
Each mode completes a fixed number of clock edges after the edge that samples `start_i`. This is zero edges for implied and rejected codes, and one edge per sequencer step otherwise: 1 for immediate, 2 or 3 for zero page, 3 for absolute, 4 on an absolute page crossing, 5 for indexed indirect, and 4 or 5 for indirect indexed. The bench drives stimulus on the falling edge and, starting at the accepting rising edge, samples every following falling edge. It counts how many edges elapse before `done_o` is seen and compares that count with the step count stated for the mode. It also tallies the read strobes and increment requests seen over the same window. On the falling edge after the pulse it confirms that `done_o` has dropped and that the held address has not moved.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

  localparam int unsigned MODE_W    = 4;
  localparam int unsigned MODE_LAST = 9;

  typedef enum logic [MODE_W-1:0] {
    MD_IMM  = 4'd0,
    MD_ZP   = 4'd1,
    MD_ZPX  = 4'd2,
    MD_ZPY  = 4'd3,
    MD_ABS  = 4'd4,
    MD_ABSX = 4'd5,
    MD_ABSY = 4'd6,
    MD_INDX = 4'd7,
    MD_INDY = 4'd8,
    MD_IMPL = 4'd9
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_LO,
    ST_FETCH_HI,
    ST_ZP_IDX,
    ST_PTR_LO,
    ST_PTR_HI,
    ST_FIX_HI,
    ST_READ
  } state_e;

  function automatic logic uses_y(mode_e m);
    return (m == MD_ZPY) || (m == MD_ABSY) || (m == MD_INDY);
  endfunction

endpackage

// File: rtl/opfetch_idx_add.sv
module opfetch_idx_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W:0] full;

  assign full    = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];
endmodule

// File: rtl/opfetch_addr_sel.sv
module opfetch_addr_sel
  import opfetch_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  state_e              state_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [DATA_W-1:0]   ptr_i,
  input  logic [ADDR_W-1:0]   ea_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                rd_o,
  output logic                pc_inc_o
);
  logic [DATA_W-1:0] ptr_nx;

  // pointer high-byte fetch stays inside page zero
  assign ptr_nx = ptr_i + DATA_W'(1);

  always_comb begin
    addr_o   = ea_i;
    rd_o     = 1'b0;
    pc_inc_o = 1'b0;
    case (state_i)
      ST_FETCH_LO, ST_FETCH_HI: begin
        addr_o   = pc_i;
        rd_o     = 1'b1;
        pc_inc_o = 1'b1;
      end
      ST_PTR_LO: begin
        addr_o = {{DATA_W{1'b0}}, ptr_i};
        rd_o   = 1'b1;
      end
      ST_PTR_HI: begin
        addr_o = {{DATA_W{1'b0}}, ptr_nx};
        rd_o   = 1'b1;
      end
      ST_READ: rd_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
  import opfetch_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DATA_W-1:0] idx_x_i,
  input  logic [DATA_W-1:0] idx_y_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              pc_inc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              reject_o,
  output logic [DATA_W-1:0] operand_o,
  output logic [ADDR_W-1:0] ea_o
);
  state_e            state_q;
  mode_e             mode_q;
  logic [DATA_W-1:0] idx_q, lo_q, opnd_q;
  logic [ADDR_W-1:0] pc_q, ea_q;
  logic              done_q, rej_q;

  logic [DATA_W-1:0] add_a, add_sum, hi_inc;
  logic              add_cy;

  // low-byte base: fetched byte, or pointed-to base low byte for indirect-Y
  assign add_a  = (state_q == ST_PTR_HI) ? ea_q[DATA_W-1:0] : lo_q;
  assign hi_inc = ea_q[ADDR_W-1:DATA_W] + DATA_W'(1);

  opfetch_idx_add #(.W(DATA_W)) u_add (
    .a_i     (add_a),
    .b_i     (idx_q),
    .sum_o   (add_sum),
    .carry_o (add_cy)
  );

  opfetch_addr_sel #(.DATA_W(DATA_W)) u_sel (
    .state_i  (state_q),
    .pc_i     (pc_q),
    .ptr_i    (lo_q),
    .ea_i     (ea_q),
    .addr_o   (mem_addr_o),
    .rd_o     (mem_rd_o),
    .pc_inc_o (pc_inc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MD_IMM;
      idx_q   <= '0;
      lo_q    <= '0;
      opnd_q  <= '0;
      pc_q    <= '0;
      ea_q    <= '0;
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (mode_i > MODE_W'(MODE_LAST)) begin
              rej_q <= 1'b1;
            end else if (mode_e'(mode_i) == MD_IMPL) begin
              done_q <= 1'b1;
            end else begin
              mode_q  <= mode_e'(mode_i);
              idx_q   <= uses_y(mode_e'(mode_i)) ? idx_y_i : idx_x_i;
              pc_q    <= pc_i;
              state_q <= ST_FETCH_LO;
            end
          end
        end
        ST_FETCH_LO: begin
          pc_q <= pc_q + ADDR_W'(1);
          lo_q <= mem_data_i;
          case (mode_q)
            MD_IMM: begin
              ea_q    <= pc_q;
              opnd_q  <= mem_data_i;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
            MD_ZP: begin
              ea_q    <= {{DATA_W{1'b0}}, mem_data_i};
              state_q <= ST_READ;
            end
            MD_ABS, MD_ABSX, MD_ABSY: state_q <= ST_FETCH_HI;
            MD_INDY:                  state_q <= ST_PTR_LO;
            default:                  state_q <= ST_ZP_IDX;
          endcase
        end
        ST_ZP_IDX: begin
          lo_q <= add_sum;
          if (mode_q == MD_INDX) begin
            state_q <= ST_PTR_LO;
          end else begin
            ea_q    <= {{DATA_W{1'b0}}, add_sum};
            state_q <= ST_READ;
          end
        end
        ST_FETCH_HI: begin
          pc_q <= pc_q + ADDR_W'(1);
          if (mode_q == MD_ABS) begin
            ea_q    <= {mem_data_i, lo_q};
            state_q <= ST_READ;
          end else begin
            ea_q    <= {mem_data_i, add_sum};
            state_q <= add_cy ? ST_FIX_HI : ST_READ;
          end
        end
        ST_PTR_LO: begin
          ea_q[DATA_W-1:0] <= mem_data_i;
          state_q          <= ST_PTR_HI;
        end
        ST_PTR_HI: begin
          if (mode_q == MD_INDX) begin
            ea_q[ADDR_W-1:DATA_W] <= mem_data_i;
            state_q               <= ST_READ;
          end else begin
            ea_q    <= {mem_data_i, add_sum};
            state_q <= add_cy ? ST_FIX_HI : ST_READ;
          end
        end
        ST_FIX_HI: begin
          ea_q[ADDR_W-1:DATA_W] <= hi_inc;
          state_q               <= ST_READ;
        end
        ST_READ: begin
          opnd_q  <= mem_data_i;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign reject_o  = rej_q;
  assign operand_o = opnd_q;
  assign ea_o      = ea_q;
endmodule

// File: rtl/opfetch_seq_chk.sv
module opfetch_seq_chk #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mem_rd_o,
  input logic              pc_inc_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              reject_o,
  input logic [DATA_W-1:0] operand_o,
  input logic [ADDR_W-1:0] ea_o
);
  assert_busy_from_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_idle_no_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_rd_o);

  assert_reject_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> (!done_o && !busy_o));

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_ea_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> ($stable(ea_o) && $stable(operand_o)));

  assert_inc_reads_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_o |-> (mem_rd_o && busy_o));
endmodule

bind opfetch_seq opfetch_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mem_rd_o  (mem_rd_o),
  .pc_inc_o  (pc_inc_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .reject_o  (reject_o),
  .operand_o (operand_o),
  .ea_o      (ea_o)
);

// File: tb/opfetch_seq_tb.sv
module opfetch_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [7:0]  idx_x_i = '0;
  logic [7:0]  idx_y_i = '0;
  logic [15:0] pc_i = '0;
  logic [15:0] mem_addr_o;
  logic        mem_rd_o;
  logic [7:0]  mem_data_i;
  logic        pc_inc_o, busy_o, done_o, reject_o;
  logic [7:0]  operand_o;
  logic [15:0] ea_o;

  logic [7:0] mem [1024];
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // 1 KiB memory model, mirrored across the address space
  assign mem_data_i = mem[mem_addr_o[9:0]];

  opfetch_seq u_dut (
    .clk_i, .rst_ni, .start_i, .mode_i, .idx_x_i, .idx_y_i, .pc_i,
    .mem_addr_o, .mem_rd_o, .mem_data_i, .pc_inc_o, .busy_o,
    .done_o, .reject_o, .operand_o, .ea_o
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    mem[a[9:0]] = d;
  endtask

  // exp_k: edges from the accepting edge until done_o is seen
  task automatic run_op(input logic [3:0] md, input logic [7:0] xv, input logic [7:0] yv,
                        input logic [15:0] pcv, input int exp_k, input logic [15:0] exp_ea,
                        input bit impl, input int exp_inc, input int exp_rd,
                        input bit hold, input string tag);
    logic [15:0] ea_b;
    logic [7:0]  op_b, exp_op;
    int j, incs, rds;
    bit seen;
    @(negedge clk_i);
    ea_b = ea_o; op_b = operand_o;
    start_i = 1'b1; mode_i = md; idx_x_i = xv; idx_y_i = yv; pc_i = pcv;
    @(posedge clk_i);
    j = 0; incs = 0; rds = 0; seen = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk_i);
      if (hold) begin
        start_i = 1'b1; mode_i = 4'd0; pc_i = 16'h0000;
      end else begin
        start_i = 1'b0;
      end
      rds += int'(mem_rd_o);
      if (done_o) begin seen = 1; break; end
      incs += int'(pc_inc_o);
      j++;
      @(posedge clk_i);
    end
    start_i = 1'b0;
    exp_op = impl ? op_b : mem[exp_ea[9:0]];
    chk(tag, "done seen", 32'(seen), 32'd1);
    chk(tag, "latency", 32'(j), 32'(exp_k));
    chk(tag, "ea", 32'(ea_o), impl ? 32'(ea_b) : 32'(exp_ea));
    chk(tag, "operand", 32'(operand_o), 32'(exp_op));
    chk({tag, " R11"}, "pc_inc count", 32'(incs), 32'(exp_inc));
    chk({tag, " R11"}, "read count", 32'(rds), 32'(exp_rd));
    ea_b = ea_o;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R10", "done pulse low", 32'(done_o), 32'd0);
    chk("R10", "ea held", 32'(ea_o), 32'(ea_b));
    chk("R1", "no restart", 32'(busy_o), 32'd0);
  endtask

  task automatic run_reject(input logic [3:0] md);
    logic [15:0] ea_b;
    @(negedge clk_i);
    ea_b = ea_o;
    start_i = 1'b1; mode_i = md;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R9", "reject pulse", 32'(reject_o), 32'd1);
    chk("R9", "no done", 32'(done_o), 32'd0);
    chk("R9", "no read", 32'(mem_rd_o), 32'd0);
    chk("R9", "not busy", 32'(busy_o), 32'd0);
    @(negedge clk_i);
    chk("R9", "reject low", 32'(reject_o), 32'd0);
    chk("R9", "ea unchanged", 32'(ea_o), 32'(ea_b));
  endtask

  task automatic t_reset();
    chk("reset", "busy", 32'(busy_o), 32'd0);
    chk("reset", "done", 32'(done_o), 32'd0);
    chk("reset", "reject", 32'(reject_o), 32'd0);
    chk("reset", "read", 32'(mem_rd_o), 32'd0);
    chk("reset", "ea", 32'(ea_o), 32'd0);
  endtask

  task automatic t_imm();
    wr(16'h0200, 8'h5C);
    run_op(4'd0, 8'h00, 8'h00, 16'h0200, 1, 16'h0200, 0, 1, 1, 0, "R2 imm");
  endtask

  task automatic t_zp();
    wr(16'h0210, 8'h40);
    run_op(4'd1, 8'h07, 8'h09, 16'h0210, 2, 16'h0040, 0, 1, 2, 0, "R3 zp");
    wr(16'h0220, 8'hF0);
    run_op(4'd2, 8'h20, 8'h00, 16'h0220, 3, 16'h0010, 0, 1, 2, 0, "R3 zpx wrap");
    wr(16'h0228, 8'h33);
    run_op(4'd3, 8'h77, 8'h05, 16'h0228, 3, 16'h0038, 0, 1, 2, 0, "R3 zpy");
  endtask

  task automatic t_abs();
    wr(16'h0230, 8'h34); wr(16'h0231, 8'h12);
    run_op(4'd4, 8'h55, 8'h66, 16'h0230, 3, 16'h1234, 0, 2, 3, 0, "R4 abs");
  endtask

  task automatic t_abs_idx();
    wr(16'h0240, 8'h10); wr(16'h0241, 8'h12);
    run_op(4'd5, 8'h05, 8'hEE, 16'h0240, 3, 16'h1215, 0, 2, 3, 0, "R5 absx no carry");
    wr(16'h0250, 8'hF0); wr(16'h0251, 8'h12);
    run_op(4'd6, 8'h00, 8'h30, 16'h0250, 4, 16'h1320, 0, 2, 3, 0, "R5 absy carry");
    wr(16'h0260, 8'hF0); wr(16'h0261, 8'hFF);
    run_op(4'd5, 8'h20, 8'h00, 16'h0260, 4, 16'h0010, 0, 2, 3, 0, "R5 absx top wrap");
  endtask

  task automatic t_indx();
    wr(16'h0270, 8'h40); wr(16'h0044, 8'h78); wr(16'h0045, 8'h16);
    run_op(4'd7, 8'h04, 8'h00, 16'h0270, 5, 16'h1678, 0, 1, 4, 0, "R6 indx");
    wr(16'h0280, 8'hFE); wr(16'h00FF, 8'h9A); wr(16'h0000, 8'h13);
    run_op(4'd7, 8'h01, 8'h00, 16'h0280, 5, 16'h139A, 0, 1, 4, 0, "R6 indx ptr wrap");
  endtask

  task automatic t_indy();
    wr(16'h0290, 8'h60); wr(16'h0060, 8'h20); wr(16'h0061, 8'h14);
    run_op(4'd8, 8'h99, 8'h10, 16'h0290, 4, 16'h1430, 0, 1, 4, 0, "R7 indy no carry");
    wr(16'h02A0, 8'h62); wr(16'h0062, 8'hE0); wr(16'h0063, 8'h14);
    run_op(4'd8, 8'h00, 8'h40, 16'h02A0, 5, 16'h1520, 0, 1, 4, 0, "R7 indy carry");
    wr(16'h02B0, 8'hFF); wr(16'h00FF, 8'h9A); wr(16'h0000, 8'h13);
    run_op(4'd8, 8'h00, 8'h01, 16'h02B0, 4, 16'h139B, 0, 1, 4, 0, "R7 indy ptr wrap");
  endtask

  task automatic t_impl();
    run_op(4'd9, 8'h00, 8'h00, 16'h0300, 0, 16'h0000, 1, 0, 0, 0, "R8 implied");
  endtask

  task automatic t_reject();
    run_reject(4'd10);
    run_reject(4'd15);
  endtask

  task automatic t_busy();
    wr(16'h0310, 8'h11); wr(16'h0311, 8'h0E);
    run_op(4'd4, 8'h00, 8'h00, 16'h0310, 3, 16'h0E11, 0, 2, 3, 1, "R1 start while busy");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_imm();
    t_zp();
    t_abs();
    t_abs_idx();
    t_indx();
    t_indy();
    t_impl();
    t_reject();
    t_busy();
    repeat (2) @(negedge clk_i);
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end
endmodule